// File: doc/BRIEF.md
# Debug Abstract Register-Access Engine

This block carries out abstract register-access commands for a hart debug unit. It sits on the debug module interface (DMI) register bus. A debugger writes a command word that names a register, an access size and a direction. The engine checks the command and then moves a value between the 32-bit message words and the target register. Integer registers are reached through a simple request/acknowledge port into the hart's register file. The ISA descriptor and a bank of pipeline-observation values are read-only and are served from local inputs.

Progress and failures are reported in a status word: a busy flag and a three-bit error code. Once an error code is set it blocks every further command until the debugger clears it bit by bit. The register file may be a reduced 16-entry file, and an access to a missing upper integer register is refused with an exception code. Accesses are allowed only while the hart is halted.

Top module: `dbg_absreg_engine`

## Requirements
- R1: After reset the status word reads busy 0 and error 0, all message words read 0, and no register-file request is raised.
- R2: The message words sit at bus addresses 0x04..0x07 (the word at 0x04 is least significant). While idle, a bus write stores the full 32 bits and a read at the same address returns them.
- R3: A write to 0x17 with bit 17 set starts an access. Bit 16 set means register ← message words, bits 15:0 hold the register number, and integer register n is number 0x1000+n. A 64-bit access (size field bits 22:20 = 3) returns the low half in word 0 and the high half in word 1, or writes {word1, word0}.
- R4: A 32-bit access (size 2) read loads word 0 only and leaves word 1 unchanged. A 32-bit write sends word 0 zero-extended.
- R5: A size other than 2 or 3 sets error 2 and touches no register.
- R6: An integer register number at or above the implemented count (x16..x31 with 16 registers) sets error 3. So does an unmapped number or a write to a read-only register.
- R7: A command issued while the hart is not halted sets error 4 and touches no register.
- R8: Busy rises in the cycle after an accepted command. The register-file request holds its address, direction and data until acknowledged, and busy falls in the cycle after the acknowledge.
- R9: A command or message-word write that arrives while busy sets error 1, is dropped, and leaves the message words unchanged. The running access still completes.
- R10: While the error code is nonzero, commands are ignored and the code is kept. Writing 0x16 clears each error bit whose bit in 10:8 is 1.
- R11: Register 0x301 returns the ISA input, and registers 0xC000+i return observation value i. Each takes one busy cycle.
- R12: A command with bit 17 clear does nothing: no busy, no error, no request.
- R13: The status word at 0x16 reads busy at bit 12, the error at bits 10:8, the message-word count (4) at bits 3:0, and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmi_req_i | input | 1 | Bus access valid this cycle |
| dmi_we_i | input | 1 | Bus access is a write |
| dmi_addr_i | input | 7 | Bus register address |
| dmi_wdata_i | input | 32 | Bus write data |
| dmi_rdata_o | output | 32 | Read data for dmi_addr_i (combinational) |
| hart_halted_i | input | 1 | Hart is halted |
| isa_i | input | XLEN | ISA descriptor value |
| obs_i | input | NUM_OBS*XLEN | Packed observation values, entry i at bits i*XLEN |
| rf_req_o | output | 1 | Register-file access request |
| rf_we_o | output | 1 | Request is a write |
| rf_addr_o | output | log2(NUM_GPR) | Integer register index |
| rf_wdata_o | output | XLEN | Write value |
| rf_rdata_i | input | XLEN | Read value, valid with rf_ack_i |
| rf_ack_i | input | 1 | Register file completes the request |

## Verification
The assertions assume that the register file answers only while a request is up and keeps its read value valid in the acknowledging cycle. They also assume that the bus carries at most one access per cycle. The bench's register-file model raises the acknowledge only while a request is up, after a chosen latency of zero to four cycles, and its read value is taken from its own array at the requested index. The halt input is changed only while the engine is idle. Every bus write is a single-cycle pulse.

// File: rtl/absreg_pkg.sv
package absreg_pkg;
  localparam logic [6:0]  ADDR_DATA0 = 7'h04;
  localparam logic [6:0]  ADDR_STAT  = 7'h16;
  localparam logic [6:0]  ADDR_CMD   = 7'h17;
  localparam int          BUSY_BIT   = 12;
  localparam int          ERR_LSB    = 8;
  localparam logic [15:0] RN_GPR     = 16'h1000;
  localparam logic [15:0] RN_ISA     = 16'h0301;
  localparam logic [15:0] RN_OBS     = 16'hC000;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_BUSY  = 3'd1,
    ERR_NOSUP = 3'd2,
    ERR_EXC   = 3'd3,
    ERR_HALT  = 3'd4
  } err_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RF, ST_LOCAL} st_e;
  typedef enum logic [1:0] {TGT_GPR, TGT_ISA, TGT_OBS, TGT_NONE} tgt_e;
endpackage

// File: rtl/absreg_decode.sv
module absreg_decode
  import absreg_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NUM_GPR = 16,
  parameter int NUM_OBS = 8
) (
  input  logic [15:0] regno_i,
  input  logic [2:0]  size_i,
  input  logic        xfer_i,
  input  logic        write_i,
  input  logic        halted_i,
  input  logic        busy_i,
  input  logic        err_free_i,
  output logic        start_o,
  output err_e        err_o,
  output tgt_e        tgt_o,
  output logic [4:0]  idx_o,
  output logic        narrow_o
);
  logic gpr_hit, gpr_ok, isa_hit, obs_hit, size_ok, reg_ok;

  assign gpr_hit  = regno_i[15:5] == RN_GPR[15:5];
  assign gpr_ok   = gpr_hit && (32'(regno_i[4:0]) < NUM_GPR);
  assign isa_hit  = regno_i == RN_ISA;
  assign obs_hit  = (regno_i >= RN_OBS) && (regno_i < RN_OBS + 16'(NUM_OBS));
  assign size_ok  = (size_i == 3'd2) || ((size_i == 3'd3) && (XLEN >= 64));
  assign reg_ok   = gpr_ok || ((isa_hit || obs_hit) && !write_i);
  assign narrow_o = (size_i == 3'd2);
  assign idx_o    = regno_i[4:0];

  always_comb begin
    if (gpr_hit)      tgt_o = TGT_GPR;
    else if (isa_hit) tgt_o = TGT_ISA;
    else if (obs_hit) tgt_o = TGT_OBS;
    else              tgt_o = TGT_NONE;
  end

  // priority: held error, busy, no transfer, size, halt, register
  always_comb begin
    start_o = 1'b0;
    err_o   = ERR_NONE;
    if (!err_free_i) begin
      start_o = 1'b0;
    end else if (busy_i) begin
      err_o = ERR_BUSY;
    end else if (!xfer_i) begin
      start_o = 1'b0;
    end else if (!size_ok) begin
      err_o = ERR_NOSUP;
    end else if (!halted_i) begin
      err_o = ERR_HALT;
    end else if (!reg_ok) begin
      err_o = ERR_EXC;
    end else begin
      start_o = 1'b1;
    end
  end
endmodule

// File: rtl/absreg_msgbuf.sv
module absreg_msgbuf #(
  parameter int XLEN       = 64,
  parameter int DATA_WORDS = 4,
  localparam int SEL_W     = $clog2(DATA_WORDS),
  localparam int LD_WORDS  = XLEN / 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [SEL_W-1:0]            wr_sel_i,
  input  logic [31:0]                 wr_data_i,
  input  logic                        ld_en_i,
  input  logic                        ld_narrow_i,
  input  logic [XLEN-1:0]             ld_val_i,
  output logic [DATA_WORDS-1:0][31:0] words_o
);
  for (genvar w = 0; w < DATA_WORDS; w++) begin : g_word
    if (w < LD_WORDS) begin : g_ld
      logic ld_here;
      assign ld_here = ld_en_i && ((w == 0) || !ld_narrow_i);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              words_o[w] <= '0;
        else if (ld_here)                         words_o[w] <= ld_val_i[w*32 +: 32];
        else if (wr_en_i && wr_sel_i == SEL_W'(w)) words_o[w] <= wr_data_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              words_o[w] <= '0;
        else if (wr_en_i && wr_sel_i == SEL_W'(w)) words_o[w] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/dbg_absreg_engine.sv
module dbg_absreg_engine
  import absreg_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int NUM_GPR    = 16,
  parameter int NUM_OBS    = 8,
  parameter int DATA_WORDS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       dmi_req_i,
  input  logic                       dmi_we_i,
  input  logic [6:0]                 dmi_addr_i,
  input  logic [31:0]                dmi_wdata_i,
  output logic [31:0]                dmi_rdata_o,
  input  logic                       hart_halted_i,
  input  logic [XLEN-1:0]            isa_i,
  input  logic [NUM_OBS*XLEN-1:0]    obs_i,
  output logic                       rf_req_o,
  output logic                       rf_we_o,
  output logic [$clog2(NUM_GPR)-1:0] rf_addr_o,
  output logic [XLEN-1:0]            rf_wdata_o,
  input  logic [XLEN-1:0]            rf_rdata_i,
  input  logic                       rf_ack_i
);
  localparam int GPR_AW   = $clog2(NUM_GPR);
  localparam int SEL_W    = $clog2(DATA_WORDS);
  localparam int LD_WORDS = XLEN / 32;

  st_e                         state_q;
  logic [2:0]                  cmderr_q;
  logic                        busy;
  logic                        wr_cmd, wr_stat, wr_msg, in_msg;
  logic [SEL_W-1:0]            msg_sel;
  logic [DATA_WORDS-1:0][31:0] words;
  logic                        dec_start, dec_narrow;
  err_e                        dec_err;
  tgt_e                        dec_tgt;
  logic [4:0]                  dec_idx;
  tgt_e                        tgt_q;
  logic [4:0]                  idx_q;
  logic                        we_q, narrow_q;
  logic [XLEN-1:0]             wdata_q, wide_w, local_val, ld_val;
  logic                        ld_en;
  logic [2:0]                  err_new;

  assign busy    = state_q != ST_IDLE;
  assign in_msg  = (dmi_addr_i >= ADDR_DATA0) && (dmi_addr_i < ADDR_DATA0 + 7'(DATA_WORDS));
  assign msg_sel = SEL_W'(dmi_addr_i - ADDR_DATA0);
  assign wr_cmd  = dmi_req_i && dmi_we_i && (dmi_addr_i == ADDR_CMD);
  assign wr_stat = dmi_req_i && dmi_we_i && (dmi_addr_i == ADDR_STAT);
  assign wr_msg  = dmi_req_i && dmi_we_i && in_msg;

  absreg_decode #(
    .XLEN   (XLEN),
    .NUM_GPR(NUM_GPR),
    .NUM_OBS(NUM_OBS)
  ) i_decode (
    .regno_i   (dmi_wdata_i[15:0]),
    .size_i    (dmi_wdata_i[22:20]),
    .xfer_i    (dmi_wdata_i[17]),
    .write_i   (dmi_wdata_i[16]),
    .halted_i  (hart_halted_i),
    .busy_i    (busy),
    .err_free_i(cmderr_q == 3'd0),
    .start_o   (dec_start),
    .err_o     (dec_err),
    .tgt_o     (dec_tgt),
    .idx_o     (dec_idx),
    .narrow_o  (dec_narrow)
  );

  // outgoing write value from the message words at command time
  always_comb begin
    wide_w = '0;
    for (int w = 0; w < LD_WORDS; w++) begin
      if ((w == 0) || !dec_narrow) wide_w[w*32 +: 32] = words[w];
    end
  end

  always_comb begin
    local_val = isa_i;
    if (tgt_q == TGT_OBS) begin
      local_val = '0;
      for (int i = 0; i < NUM_OBS; i++) begin
        if (idx_q == 5'(i)) local_val = obs_i[i*XLEN +: XLEN];
      end
    end
  end

  assign ld_en  = ((state_q == ST_RF) && rf_ack_i && !we_q) || (state_q == ST_LOCAL);
  assign ld_val = (state_q == ST_RF) ? rf_rdata_i : local_val;

  absreg_msgbuf #(
    .XLEN      (XLEN),
    .DATA_WORDS(DATA_WORDS)
  ) i_msgbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_msg && !busy),
    .wr_sel_i   (msg_sel),
    .wr_data_i  (dmi_wdata_i),
    .ld_en_i    (ld_en),
    .ld_narrow_i(narrow_q),
    .ld_val_i   (ld_val),
    .words_o    (words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tgt_q    <= TGT_NONE;
      idx_q    <= '0;
      we_q     <= 1'b0;
      narrow_q <= 1'b0;
      wdata_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (wr_cmd && dec_start) begin
            state_q  <= (dec_tgt == TGT_GPR) ? ST_RF : ST_LOCAL;
            tgt_q    <= dec_tgt;
            idx_q    <= dec_idx;
            we_q     <= dmi_wdata_i[16];
            narrow_q <= dec_narrow;
            wdata_q  <= wide_w;
          end
        end
        ST_RF:    if (rf_ack_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    err_new = ERR_NONE;
    if (wr_cmd)                err_new = dec_err;
    else if (wr_msg && busy)   err_new = ERR_BUSY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cmderr_q <= '0;
    else if (wr_stat)                            cmderr_q <= cmderr_q & ~dmi_wdata_i[ERR_LSB +: 3];
    else if (cmderr_q == 3'd0 && err_new != 3'd0) cmderr_q <= err_new;
  end

  always_comb begin
    dmi_rdata_o = '0;
    if (dmi_addr_i == ADDR_STAT) begin
      dmi_rdata_o[BUSY_BIT]       = busy;
      dmi_rdata_o[ERR_LSB +: 3]   = cmderr_q;
      dmi_rdata_o[3:0]            = 4'(DATA_WORDS);
    end else if (in_msg) begin
      dmi_rdata_o = words[msg_sel];
    end
  end

  assign rf_req_o   = state_q == ST_RF;
  assign rf_we_o    = we_q;
  assign rf_addr_o  = idx_q[GPR_AW-1:0];
  assign rf_wdata_o = wdata_q;
endmodule

// File: rtl/absreg_chk.sv
module absreg_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dmi_req_i,
  input logic          dmi_we_i,
  input logic [6:0]    dmi_addr_i,
  input logic          hart_halted_i,
  input logic          rf_req_o,
  input logic          rf_we_o,
  input logic [AW-1:0] rf_addr_o,
  input logic          rf_ack_i,
  input logic          busy_i,
  input logic [2:0]    cmderr_i
);
  logic wr_stat, wr_cmd;
  assign wr_stat = dmi_req_i && dmi_we_i && (dmi_addr_i == 7'h16);
  assign wr_cmd  = dmi_req_i && dmi_we_i && (dmi_addr_i == 7'h17);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_req_o && !rf_ack_i |=> rf_req_o && $stable(rf_addr_o) && $stable(rf_we_o)); // R8
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_req_o && rf_ack_i |=> !rf_req_o && !busy_i); // R8
  AST_BUSY_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd && busy_i && cmderr_i == 3'd0 |=> cmderr_i == 3'd1); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmderr_i != 3'd0 && !wr_stat |=> $stable(cmderr_i)); // R10
  AST_NO_START_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmderr_i != 3'd0 && !busy_i |=> !rf_req_o); // R10
  AST_NOT_HALTED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !hart_halted_i |=> !rf_req_o); // R7
endmodule

bind dbg_absreg_engine absreg_chk #(.AW($clog2(NUM_GPR))) i_absreg_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dmi_req_i    (dmi_req_i),
  .dmi_we_i     (dmi_we_i),
  .dmi_addr_i   (dmi_addr_i),
  .hart_halted_i(hart_halted_i),
  .rf_req_o     (rf_req_o),
  .rf_we_o      (rf_we_o),
  .rf_addr_o    (rf_addr_o),
  .rf_ack_i     (rf_ack_i),
  .busy_i       (busy),
  .cmderr_i     (cmderr_q)
);

// File: tb/test_dbg_absreg_engine.sv
module test_dbg_absreg_engine;
  timeunit 1ns; timeprecision 1ps;

  localparam int XLEN = 64, NG = 16, NO = 8;
  localparam logic [63:0] ISA_VAL = 64'h8000_0000_0014_1105;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dmi_req = 0, dmi_we = 0, halted = 1;
  logic [6:0] dmi_addr = 7'h16;
  logic [31:0] dmi_wdata = '0, dmi_rdata;
  logic [XLEN-1:0] isa = ISA_VAL, rf_wdata, rf_rdata;
  logic [NO*XLEN-1:0] obs;
  logic rf_req, rf_we, rf_ack;
  logic [3:0] rf_addr;

  int checks = 0, fails = 0, lat = 0, wcnt = 0;
  string tag = "R8";
  logic [63:0] gpr [NG];

  always #5 clk = ~clk;

  function automatic logic [63:0] obs_val(int i);
    return 64'hC0DE_0000_0000_0000 + 64'(i) * 64'h1111;
  endfunction
  function automatic logic [63:0] gpr_init(int i);
    return {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)};
  endfunction
  function automatic logic [31:0] mk_cmd(int size, bit wr, bit xfer, logic [15:0] rn);
    return (32'(size) << 20) | (32'(xfer) << 17) | (32'(wr) << 16) | 32'(rn);
  endfunction

  initial for (int i = 0; i < NO; i++) obs[i*XLEN +: XLEN] = obs_val(i);

  dbg_absreg_engine i_dbg_absreg_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .dmi_req_i(dmi_req), .dmi_we_i(dmi_we), .dmi_addr_i(dmi_addr),
    .dmi_wdata_i(dmi_wdata), .dmi_rdata_o(dmi_rdata),
    .hart_halted_i(halted), .isa_i(isa), .obs_i(obs),
    .rf_req_o(rf_req), .rf_we_o(rf_we), .rf_addr_o(rf_addr),
    .rf_wdata_o(rf_wdata), .rf_rdata_i(rf_rdata), .rf_ack_i(rf_ack)
  );

  // register-file model
  assign rf_ack   = rf_req && (wcnt >= lat);
  assign rf_rdata = gpr[rf_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= 0;
      for (int i = 0; i < NG; i++) gpr[i] <= gpr_init(i);
    end else begin
      wcnt <= (rf_req && !rf_ack) ? wcnt + 1 : 0;
      if (rf_ack && rf_we) gpr[rf_addr] <= rf_wdata;
    end
  end

  // reference model
  int m_state, m_idx, m_tgt, m_err;
  bit m_we, m_nar;
  logic [31:0] m_data [4];
  logic [63:0] m_wd;

  task automatic m_load(logic [63:0] v);
    m_data[0] = v[31:0];
    if (!m_nar) m_data[1] = v[63:32];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_err = 0; m_we = 0; m_nar = 0; m_idx = 0; m_tgt = 0; m_wd = '0;
      for (int i = 0; i < 4; i++) m_data[i] = '0;
    end else begin
      bit busy_pre;
      busy_pre = m_state != 0;
      if (m_state == 1 && rf_ack) begin
        if (!m_we) m_load(gpr[m_idx]);
        m_state = 0;
      end else if (m_state == 2) begin
        m_load(m_tgt == 1 ? ISA_VAL : obs_val(m_idx));
        m_state = 0;
      end
      if (dmi_req && dmi_we) begin
        if (dmi_addr == 7'h16) m_err = m_err & ~int'(dmi_wdata[10:8]);
        else if (dmi_addr >= 7'h04 && dmi_addr <= 7'h07) begin
          if (busy_pre) begin if (m_err == 0) m_err = 1; end
          else m_data[dmi_addr - 7'h04] = dmi_wdata;
        end else if (dmi_addr == 7'h17 && m_err == 0) begin
          int sz, rn;
          sz = int'(dmi_wdata[22:20]); rn = int'(dmi_wdata[15:0]);
          if (busy_pre) m_err = 1;
          else if (dmi_wdata[17]) begin
            if (sz != 2 && sz != 3) m_err = 2;
            else if (!halted) m_err = 4;
            else if (rn >= 'h1000 && rn <= 'h101F) begin
              if (rn - 'h1000 >= NG) m_err = 3;
              else begin
                m_state = 1; m_idx = rn - 'h1000; m_we = dmi_wdata[16]; m_nar = (sz == 2);
                m_wd = m_nar ? {32'h0, m_data[0]} : {m_data[1], m_data[0]};
              end
            end else if (rn == 'h301 && !dmi_wdata[16]) begin
              m_state = 2; m_tgt = 1; m_nar = (sz == 2);
            end else if (rn >= 'hC000 && rn < 'hC000 + NO && !dmi_wdata[16]) begin
              m_state = 2; m_tgt = 2; m_idx = rn - 'hC000; m_nar = (sz == 2);
            end else m_err = 3;
          end
        end
      end
    end
  end

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata(logic [6:0] a);
    if (a == 7'h16) return (32'(m_state != 0) << 12) | (32'(m_err) << 8) | 32'd4;
    if (a >= 7'h04 && a <= 7'h07) return m_data[a - 7'h04];
    return '0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(tag, 64'(rf_req), 64'(m_state == 1), "rf_req");
      if (m_state == 1) begin
        chk(tag, 64'(rf_we), 64'(m_we), "rf_we");
        chk(tag, 64'(rf_addr), 64'(m_idx), "rf_addr");
        if (m_we) chk(tag, rf_wdata, m_wd, "rf_wdata");
      end
      chk(tag, 64'(dmi_rdata), 64'(m_rdata(dmi_addr)), "rdata");
    end
  end

  task automatic dmi_wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); #1;
    dmi_req = 1; dmi_we = 1; dmi_addr = a; dmi_wdata = d;
    @(posedge clk); #1;
    dmi_req = 0; dmi_we = 0;
  endtask

  task automatic rd_chk(string t, logic [6:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    dmi_addr = a;
    #1 chk(t, 64'(dmi_rdata), 64'(exp), "read");
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      dmi_addr = 7'h16;
      #1 if (!dmi_rdata[12]) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R13: reset state
    rd_chk("R1", 7'h16, 32'h4);
    rd_chk("R13", 7'h16, 32'h4);
    rd_chk("R1", 7'h04, 32'h0);
    rd_chk("R1", 7'h07, 32'h0);
    // R2: message words
    tag = "R2";
    for (int i = 0; i < 4; i++) dmi_wr(7'h04 + 7'(i), 32'h1111_0000 * 32'(i + 1) + 32'(i));
    for (int i = 0; i < 4; i++) rd_chk("R2", 7'h04 + 7'(i), 32'h1111_0000 * 32'(i + 1) + 32'(i));
    // R3: 64-bit read of x5
    tag = "R3";
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h1005)); wait_idle();
    rd_chk("R3", 7'h04, 32'h5000_0005);
    rd_chk("R3", 7'h05, 32'hA000_0005);
    // R3: 64-bit write of x7
    dmi_wr(7'h04, 32'h89AB_CDEF); dmi_wr(7'h05, 32'h0123_4567);
    dmi_wr(7'h17, mk_cmd(3, 1, 1, 16'h1007)); wait_idle();
    chk("R3", gpr[7], 64'h0123_4567_89AB_CDEF, "x7 after write");
    // R4: narrow read keeps word 1, narrow write zero-extends
    tag = "R4";
    dmi_wr(7'h05, 32'hFEED_FACE);
    dmi_wr(7'h17, mk_cmd(2, 0, 1, 16'h1003)); wait_idle();
    rd_chk("R4", 7'h04, 32'h5000_0003);
    rd_chk("R4", 7'h05, 32'hFEED_FACE);
    dmi_wr(7'h04, 32'hCAFE_0001);
    dmi_wr(7'h17, mk_cmd(2, 1, 1, 16'h1009)); wait_idle();
    chk("R4", gpr[9], 64'h0000_0000_CAFE_0001, "x9 narrow write");
    // R5: bad size
    tag = "R5";
    dmi_wr(7'h17, mk_cmd(4, 0, 1, 16'h1001)); wait_idle();
    rd_chk("R5", 7'h16, 32'h204);
    dmi_wr(7'h16, 32'h700);
    rd_chk("R10", 7'h16, 32'h4);
    // R6: missing upper GPR, unmapped, read-only write
    tag = "R6";
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h1014)); wait_idle();
    rd_chk("R6", 7'h16, 32'h304);
    dmi_wr(7'h16, 32'h700);
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h2000)); wait_idle();
    rd_chk("R6", 7'h16, 32'h304);
    dmi_wr(7'h16, 32'h700);
    dmi_wr(7'h17, mk_cmd(3, 1, 1, 16'h0301)); wait_idle();
    rd_chk("R6", 7'h16, 32'h304);
    // R10: partial clear 3 -> 2, command ignored while error held
    tag = "R10";
    dmi_wr(7'h16, 32'h100);
    rd_chk("R10", 7'h16, 32'h204);
    dmi_wr(7'h17, mk_cmd(3, 1, 1, 16'h1004)); wait_idle();
    chk("R10", gpr[4], gpr_init(4), "x4 untouched");
    rd_chk("R10", 7'h16, 32'h204);
    dmi_wr(7'h16, 32'h700);
    // R7: hart running
    tag = "R7";
    halted = 0;
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h1001)); wait_idle();
    rd_chk("R7", 7'h16, 32'h404);
    halted = 1;
    dmi_wr(7'h16, 32'h700);
    // R8: register-file latency
    tag = "R8";
    lat = 3;
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h1002));
    rd_chk("R8", 7'h16, 32'h1004);
    wait_idle();
    rd_chk("R8", 7'h16, 32'h4);
    rd_chk("R8", 7'h04, 32'h5000_0002);
    // R9: writes while busy
    tag = "R9";
    lat = 4;
    dmi_wr(7'h06, 32'h0000_00AA);
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h1001));
    dmi_wr(7'h06, 32'h0000_00BB);
    wait_idle();
    rd_chk("R9", 7'h16, 32'h104);
    rd_chk("R9", 7'h06, 32'h0000_00AA);
    rd_chk("R9", 7'h04, 32'h5000_0001);
    dmi_wr(7'h16, 32'h700);
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h1001));
    dmi_wr(7'h17, mk_cmd(3, 1, 1, 16'h1002));
    wait_idle();
    chk("R9", gpr[2], gpr_init(2), "x2 untouched");
    rd_chk("R9", 7'h16, 32'h104);
    dmi_wr(7'h16, 32'h700);
    lat = 0;
    // R11: ISA and observation registers
    tag = "R11";
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'h0301)); wait_idle();
    rd_chk("R11", 7'h04, ISA_VAL[31:0]);
    rd_chk("R11", 7'h05, ISA_VAL[63:32]);
    dmi_wr(7'h17, mk_cmd(3, 0, 1, 16'hC003)); wait_idle();
    rd_chk("R11", 7'h04, obs_val(3)[31:0]);
    rd_chk("R11", 7'h05, obs_val(3)[63:32]);
    // R12: transfer bit clear
    tag = "R12";
    dmi_wr(7'h17, mk_cmd(3, 1, 0, 16'h1006));
    rd_chk("R12", 7'h16, 32'h4);
    repeat (3) @(negedge clk);
    chk("R12", gpr[6], gpr_init(6), "x6 untouched");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule